// File: doc/BRIEF.md
# Byte-Serial Iterative DES Encryption Core

This block encrypts 64-bit blocks with the Data Encryption Standard, spending one clock on each of the sixteen Feistel rounds. A plaintext block arrives as eight bytes over a narrow input port. Once the eighth byte is in, the initial permutation loads the two 32-bit half registers, and one shared round function is stepped sixteen times. The final permutation result is then shifted out as eight bytes, each marked by a valid strobe.

Round keys are not derived inside the block. Software or a neighbouring block writes the sixteen 48-bit subkeys once into a bank of dedicated registers, and they stay there across any number of blocks and across reset. A one-cycle marker pulse flags the start of every plaintext transfer, so that external capture equipment can line its sample windows up to the internal register activity. A busy flag refuses new plaintext from the end of the input transfer until the last ciphertext byte has left.

Top module: `des_byteserial`

## Requirements
- R1: On every rising edge with `in_valid` high while the core is idle or collecting a block, `in_data` is taken as the next byte; the first byte taken becomes plaintext bits 63:56 and the eighth becomes bits 7:0, and cycles with `in_valid` low in between only pause the collection.
- R2: `trig` is high for exactly one cycle, the cycle right after the edge that takes the first byte of a block, and low at every other time.
- R3: The rounds take exactly sixteen edges: the first ciphertext byte is on `out_data` with `out_valid` high right after the sixteenth edge that follows the edge taking the eighth plaintext byte.
- R4: A rising edge with `key_we` high stores `key_din` into subkey slot `key_idx`; slot k (0 to 15) feeds round k+1, so slots written in reverse order make the core decrypt, and the slots keep their contents across blocks.
- R5: The ciphertext is standard DES: initial permutation, sixteen rounds in which R becomes L xor F(R, Kk) and L takes the old R, no swap after the last round, then the final permutation; for example the subkeys of key 133457799BBCDFF1 map 0123456789ABCDEF to 85E813540F0AB405.
- R6: The ciphertext leaves in eight consecutive cycles with `out_valid` high, bits 63:56 first and bits 7:0 last.
- R7: `busy` is high from the cycle after the first byte is taken until the cycle after the last ciphertext byte, and `in_valid` has no effect during the round and output cycles.
- R8: A synchronous reset drives `busy`, `trig` and `out_valid` low at the next edge and discards a partly collected block, while the subkey slots keep their contents.
- R9: A byte offered in the cycle of the last ciphertext byte is not taken; it is taken at the first edge at which `busy` is low, and that block encrypts normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| key_we | input | 1 | Subkey write strobe |
| key_idx | input | 4 | Subkey slot to write (0 = first round) |
| key_din | input | 48 | Subkey value |
| in_valid | input | 1 | Plaintext byte present |
| in_data | input | 8 | Plaintext byte, most significant first |
| busy | output | 1 | Block in flight; new plaintext refused once collection ends |
| trig | output | 1 | One-cycle marker at the start of a plaintext transfer |
| out_valid | output | 1 | Ciphertext byte present |
| out_data | output | 8 | Ciphertext byte, most significant first |

## Verification
The two functions that can meet in one cycle are the final ciphertext beat and the acceptance of the first plaintext byte of the next block. The bench provokes this by raising `in_valid` with that byte while the previous block is still being sent and holding it through the last output cycle until `busy` drops. It judges the result by requiring `trig` to stay low for every held cycle and the next block's ciphertext to match exactly, since an early acceptance would take the held byte twice and shift the whole plaintext.

// File: rtl/des_pkg.sv
package des_pkg;

    localparam int BLK_W    = 64;
    localparam int HALF_W   = 32;
    localparam int RK_W     = 48;
    localparam int N_ROUNDS = 16;
    localparam int N_SBOX   = 8;
    localparam int RND_W    = $clog2(N_ROUNDS);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ROUND,
        ST_SEND
    } phase_e;

    // Source bit (1 = most significant) for each output bit of the initial permutation.
    localparam int IP_TAB [64] = '{
        58, 50, 42, 34, 26, 18, 10,  2,
        60, 52, 44, 36, 28, 20, 12,  4,
        62, 54, 46, 38, 30, 22, 14,  6,
        64, 56, 48, 40, 32, 24, 16,  8,
        57, 49, 41, 33, 25, 17,  9,  1,
        59, 51, 43, 35, 27, 19, 11,  3,
        61, 53, 45, 37, 29, 21, 13,  5,
        63, 55, 47, 39, 31, 23, 15,  7
    };

    // Source bit for each output bit of the round permutation after the S-boxes.
    localparam int P_TAB [32] = '{
        16,  7, 20, 21, 29, 12, 28, 17,
         1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9,
        19, 13, 30,  6, 22, 11,  4, 25
    };

    // Four rows per box, sixteen nibbles per row, column 0 in the top nibble.
    localparam logic [63:0] SBOX_ROWS [32] = '{
        64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
        64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
        64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
        64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
        64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
        64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
        64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
        64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B
    };

    function automatic logic [BLK_W-1:0] ip_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) begin
            y[BLK_W-1-i] = x[BLK_W-IP_TAB[i]];
        end
        return y;
    endfunction

    // Inverse of ip_perm, derived from the same table.
    function automatic logic [BLK_W-1:0] fp_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        y = '0;
        for (int i = 0; i < BLK_W; i++) begin
            y[BLK_W-IP_TAB[i]] = x[BLK_W-1-i];
        end
        return y;
    endfunction

    // Expansion: each 6-bit group takes its 4-bit slice plus one neighbour bit on each side.
    function automatic logic [RK_W-1:0] expand(input logic [HALF_W-1:0] r);
        logic [RK_W-1:0] e;
        int src;
        e = '0;
        for (int j = 0; j < RK_W; j++) begin
            src = 4 * (j / 6) + (j % 6);
            if (src == 0)
                src = HALF_W;
            else if (src == HALF_W + 1)
                src = 1;
            e[RK_W-1-j] = r[HALF_W-src];
        end
        return e;
    endfunction

    function automatic logic [HALF_W-1:0] p_perm(input logic [HALF_W-1:0] x);
        logic [HALF_W-1:0] y;
        y = '0;
        for (int i = 0; i < HALF_W; i++) begin
            y[HALF_W-1-i] = x[HALF_W-P_TAB[i]];
        end
        return y;
    endfunction

    // Outer bits pick the row, inner four bits the column.
    function automatic logic [3:0] sbox_look(input int box, input logic [5:0] six);
        logic [63:0] row_bits;
        int          row;
        int          col;
        row      = {30'd0, six[5], six[0]};
        col      = {28'd0, six[4:1]};
        row_bits = SBOX_ROWS[box*4 + row];
        return row_bits[63-4*col -: 4];
    endfunction

endpackage

// File: rtl/des_keybank.sv
module des_keybank #(
    parameter int N_KEYS = 16,
    parameter int KEY_W  = 48,
    localparam int IDX_W = $clog2(N_KEYS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [KEY_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [KEY_W-1:0] rdata
);

    logic [KEY_W-1:0] slot_q [N_KEYS];
    logic [KEY_W-1:0] slot_d [N_KEYS];

    always_comb begin
        slot_d = slot_q;
        if (we) begin
            slot_d[widx] = wdata;
        end
    end

    // Subkeys are configuration: they survive reset on purpose.
    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign rdata = slot_q[ridx];

endmodule

// File: rtl/des_sbox_layer.sv
module des_sbox_layer
    import des_pkg::*;
(
    input  logic [RK_W-1:0]   x,
    output logic [HALF_W-1:0] y
);

    for (genvar g = 0; g < N_SBOX; g++) begin : g_box
        assign y[HALF_W-1-4*g -: 4] = sbox_look(g, x[RK_W-1-6*g -: 6]);
    end

endmodule

// File: rtl/des_feistel.sv
module des_feistel
    import des_pkg::*;
(
    input  logic [HALF_W-1:0] r,
    input  logic [RK_W-1:0]   k,
    output logic [HALF_W-1:0] f
);

    logic [RK_W-1:0]   mixed;
    logic [HALF_W-1:0] subst;

    assign mixed = expand(r) ^ k;

    des_sbox_layer u_sbox (
        .x (mixed),
        .y (subst)
    );

    assign f = p_perm(subst);

endmodule

// File: rtl/des_byteserial.sv
module des_byteserial #(
    parameter int IO_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        key_we,
    input  logic [des_pkg::RND_W-1:0]   key_idx,
    input  logic [des_pkg::RK_W-1:0]    key_din,
    input  logic                        in_valid,
    input  logic [IO_W-1:0]             in_data,
    output logic                        busy,
    output logic                        trig,
    output logic                        out_valid,
    output logic [IO_W-1:0]             out_data
);
    import des_pkg::*;

    localparam int BEATS  = BLK_W / IO_W;
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
    localparam logic [RND_W-1:0]  LAST_RND  = RND_W'(N_ROUNDS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [BEAT_W-1:0]   beat;
        logic [RND_W-1:0]    rnd;
        logic [BLK_W-1:0]    inbuf;
        logic [HALF_W-1:0]   left;
        logic [HALF_W-1:0]   right;
        logic [BLK_W-1:0]    obuf;
        logic                trig;
    } core_t;

    core_t q, d;

    logic [RK_W-1:0]   round_key;
    logic [HALF_W-1:0] f_out;
    logic [HALF_W-1:0] next_r;
    logic [BLK_W-1:0]  word;
    logic [BLK_W-1:0]  ip_word;
    logic [BLK_W-1:0]  ct_word;

    des_keybank #(
        .N_KEYS (N_ROUNDS),
        .KEY_W  (RK_W)
    ) u_keys (
        .clk   (clk),
        .we    (key_we),
        .widx  (key_idx),
        .wdata (key_din),
        .ridx  (q.rnd),
        .rdata (round_key)
    );

    des_feistel u_round (
        .r (q.right),
        .k (round_key),
        .f (f_out)
    );

    // Shared datapath terms.
    assign word    = (q.inbuf << IO_W) | BLK_W'(in_data);
    assign ip_word = ip_perm(word);
    assign next_r  = q.left ^ f_out;
    assign ct_word = fp_perm({next_r, q.right});

    always_comb begin
        d      = q;
        d.trig = 1'b0;
        case (q.phase)
            ST_IDLE: begin
                if (in_valid) begin
                    d.inbuf = word;
                    d.beat  = BEAT_W'(1);
                    d.trig  = 1'b1;
                    d.phase = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    d.inbuf = word;
                    if (q.beat == LAST_BEAT) begin
                        d.left  = ip_word[BLK_W-1 -: HALF_W];
                        d.right = ip_word[HALF_W-1:0];
                        d.rnd   = '0;
                        d.beat  = '0;
                        d.phase = ST_ROUND;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            ST_ROUND: begin
                d.left  = q.right;
                d.right = next_r;
                if (q.rnd == LAST_RND) begin
                    // Last round: halves leave unswapped straight into the output shifter.
                    d.obuf  = ct_word;
                    d.beat  = '0;
                    d.phase = ST_SEND;
                end else begin
                    d.rnd = q.rnd + 1'b1;
                end
            end
            ST_SEND: begin
                d.obuf = q.obuf << IO_W;
                if (q.beat == LAST_BEAT) begin
                    d.beat  = '0;
                    d.phase = ST_IDLE;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            default: begin
                d.phase = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.phase != ST_IDLE);
    assign out_valid = (q.phase == ST_SEND);
    assign out_data  = q.obuf[BLK_W-1 -: IO_W];
    assign trig      = q.trig;

    // R2: marker lasts one cycle only
    a_r2_trig_single: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);

    // R2: an accepted first byte raises the marker and busy
    a_r2_trig_on_start: assert property (@(posedge clk) disable iff (rst)
        (!busy && in_valid) |=> (trig && busy));

    // R3: rounds advance by one per clock with no stall
    a_r3_round_step: assert property (@(posedge clk) disable iff (rst)
        (q.phase == ST_ROUND && q.rnd != LAST_RND)
        |=> (q.phase == ST_ROUND && q.rnd == $past(q.rnd) + 1'b1));

    // R3: sixteenth round hands straight over to output
    a_r3_round_to_send: assert property (@(posedge clk) disable iff (rst)
        (q.phase == ST_ROUND && q.rnd == LAST_RND) |=> out_valid);

    // R6: output beats only while busy, and never a single isolated beat
    a_r6_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

    a_r6_send_continues: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |=> out_valid);

    // R7: input shifter frozen during rounds and output
    a_r7_input_frozen: assert property (@(posedge clk) disable iff (rst)
        (q.phase == ST_ROUND || q.phase == ST_SEND) |=> $stable(q.inbuf));

endmodule

// File: tb/des_byteserial_bench.sv
module des_byteserial_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        key_we;
    logic [3:0]  key_idx;
    logic [47:0] key_din;
    logic        in_valid;
    logic [7:0]  in_data;
    logic        busy;
    logic        trig;
    logic        out_valid;
    logic [7:0]  out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0]  exp_q [$];
    logic [47:0] sub_tab [16];
    int          run_len = 0;

    always #10 clk = ~clk;

    des_byteserial u_des_byteserial (
        .clk       (clk),
        .rst       (rst),
        .key_we    (key_we),
        .key_idx   (key_idx),
        .key_din   (key_din),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .busy      (busy),
        .trig      (trig),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    localparam int PC1_T [56] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };
    localparam int PC2_T [48] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent subkey derivation for the bench.
    function automatic void derive_subkeys(input logic [63:0] key);
        logic [55:0] cd;
        logic [27:0] c;
        logic [27:0] dd;
        int          sh;
        for (int j = 0; j < 56; j++) cd[55-j] = key[64-PC1_T[j]];
        c  = cd[55:28];
        dd = cd[27:0];
        for (int r = 0; r < 16; r++) begin
            sh = (r == 0 || r == 1 || r == 8 || r == 15) ? 1 : 2;
            for (int s = 0; s < sh; s++) begin
                c  = {c[26:0], c[27]};
                dd = {dd[26:0], dd[27]};
            end
            cd = {c, dd};
            for (int j = 0; j < 48; j++) sub_tab[r][47-j] = cd[56-PC2_T[j]];
        end
    endfunction

    task automatic load_keys(input logic [63:0] key, input bit reverse);
        derive_subkeys(key);
        while (busy) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            key_we  = 1'b1;
            key_idx = reverse ? 4'(15 - i) : 4'(i);
            key_din = sub_tab[i];
            @(negedge clk);
        end
        key_we = 1'b0;
    endtask

    // Driver: queues the expected bytes, then feeds the plaintext.
    task automatic send_block(input logic [63:0] pt, input logic [63:0] ct,
                              input int gap, input bit hold, input bit poke);
        int cnt;
        for (int i = 0; i < 8; i++) exp_q.push_back(ct[63-8*i -: 8]);
        if (hold) begin
            in_valid = 1'b1;
            in_data  = pt[63:56];
            while (busy) begin
                check("R9 no start while busy (trig)", {63'd0, trig}, 64'd0);
                @(negedge clk);
            end
        end else begin
            while (busy) @(negedge clk);
        end
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1;
            in_data  = pt[63-8*i -: 8];
            @(negedge clk);
            if (i == 0) check("R2 trig after first byte", {63'd0, trig}, 64'd1);
            if (i == 1) check("R2 trig back low", {63'd0, trig}, 64'd0);
            if (gap > 0 && i < 7) begin
                in_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        in_valid = 1'b0;
        check("R7 busy after input", {63'd0, busy}, 64'd1);
        cnt = 0;
        while (!out_valid) begin
            if (poke && cnt >= 2 && cnt < 10) begin
                in_valid = 1'b1;
                in_data  = 8'h5A;
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
            cnt++;
            if (poke) check("R7 no trig from ignored input", {63'd0, trig}, 64'd0);
        end
        in_valid = 1'b0;
        check("R3 round latency", 64'(cnt), 64'd16);
    endtask

    // Monitor: pops and compares every ciphertext byte, tracks burst length.
    always @(negedge clk) begin
        if (rst) begin
            run_len = 0;
        end else if (out_valid) begin
            run_len++;
            if (exp_q.size() == 0) begin
                check("R5 R6 unexpected output byte", {56'd0, out_data}, 64'hFFFF);
            end else begin
                check("R5 R6 ciphertext byte", {56'd0, out_data}, {56'd0, exp_q.pop_front()});
            end
        end else if (run_len != 0) begin
            check("R6 burst length", 64'(run_len), 64'd8);
            run_len = 0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        key_we   = 1'b0;
        key_idx  = '0;
        key_din  = '0;
        in_valid = 1'b0;
        in_data  = '0;
        repeat (3) @(negedge clk);
        check("R8 busy in reset", {63'd0, busy}, 64'd0);
        check("R8 out_valid in reset", {63'd0, out_valid}, 64'd0);
        check("R8 trig in reset", {63'd0, trig}, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R5 R1: known vector, back to back then with pauses between bytes
        load_keys(64'h133457799BBCDFF1, 1'b0);
        send_block(64'h0123456789ABCDEF, 64'h85E813540F0AB405, 0, 1'b0, 1'b0);
        send_block(64'h0123456789ABCDEF, 64'h85E813540F0AB405, 2, 1'b0, 1'b0);

        // R7: input strobes during rounds are ignored
        load_keys(64'h0E329232EA6D0D73, 1'b0);
        send_block(64'h8787878787878787, 64'h0000000000000000, 0, 1'b0, 1'b1);
        send_block(64'h8787878787878787, 64'h0000000000000000, 1, 1'b0, 1'b0);

        // R4: reversed slots decrypt
        load_keys(64'h133457799BBCDFF1, 1'b1);
        send_block(64'h85E813540F0AB405, 64'h0123456789ABCDEF, 0, 1'b0, 1'b0);
        // R9: first byte held through the last output beat
        send_block(64'h85E813540F0AB405, 64'h0123456789ABCDEF, 0, 1'b1, 1'b0);

        // R8: reset during collection discards it, subkeys survive
        while (busy || exp_q.size() != 0) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b1;
            in_data  = 8'hC3;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R8 busy cleared by reset", {63'd0, busy}, 64'd0);
        check("R8 trig cleared by reset", {63'd0, trig}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle after reset", {63'd0, busy}, 64'd0);
        send_block(64'h85E813540F0AB405, 64'h0123456789ABCDEF, 0, 1'b0, 1'b0);

        // R5: further vectors
        load_keys(64'h0000000000000000, 1'b0);
        send_block(64'h0000000000000000, 64'h8CA64DE9C1B123A7, 0, 1'b0, 1'b0);
        load_keys(64'h0123456789ABCDEF, 1'b0);
        send_block(64'h4E6F772069732074, 64'h3FA40E8A984D4815, 1, 1'b0, 1'b1);

        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R6 all expected bytes seen", 64'(exp_q.size()), 64'd0);
        check("R2 trig idle at end", {63'd0, trig}, 64'd0);

        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule